// File: doc/BRIEF.md
# Dual Ready Wait-State Synchronizer

This block merges several bus-ready requests into the one ready level that a processor samples to decide whether to add wait states. Each request has its own active-low enable. A request counts only while its enable is low, and the qualified requests are ORed together. The merged level is then registered before it reaches the processor, so that the processor sees a ready level that changes only at known points of its own clock.

The block runs entirely on the master clock. It does not build the processor clock itself. A divide-by-three clock divider supplies two single-cycle strobes: one marks the master cycle where the processor clock rises, the other the cycle where it falls. A mode input chooses the path at run time. In two-stage mode a first register captures the merged level at the rising strobe, and the output register takes that captured value at the next falling strobe. In one-stage mode the first register is bypassed, and the output register captures the merged level directly at the falling strobe. A low output means "not ready" and inserts wait states.

Top module: `wait_ready_sync`

## Requirements
- R1: Source i is qualified when `rdy_req[i]`=1 and `rdy_en_n[i]`=0. The merged level is the OR of all qualified sources.
- R2: A source whose `rdy_en_n` bit is 1 has no effect on `ready_o`, whatever its `rdy_req` bit.
- R3: With `stage_sel`=0 (two-stage), at a master edge where `proc_fall_en`=1, `ready_o` takes the first-stage value. The first stage holds the merged level captured at the most recent `proc_rise_en` edge.
- R4: With `stage_sel`=1 (one-stage), at a master edge where `proc_fall_en`=1, `ready_o` takes the merged level present at that edge.
- R5: `ready_o` changes only after master edges where `proc_fall_en`=1. At every other edge it holds.
- R6: The first stage loads only at edges where `proc_rise_en`=1. A qualified pulse that starts after a rise strobe and ends before the next rise strobe never reaches `ready_o` in two-stage mode.
- R7: While `rst_n`=0, both stages are cleared to not-ready, and `ready_o` reads 0. The first stage stays 0 after release until its first rise strobe.
- R8: `proc_rise_en` and `proc_fall_en` are never 1 in the same master cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_rise_en | input | 1 | Strobe: processor clock rises at this master edge |
| proc_fall_en | input | 1 | Strobe: processor clock falls at this master edge |
| stage_sel | input | 1 | 0 = two synchronizing stages, 1 = one stage |
| rdy_req | input | NUM_SRC | Ready request per source, 1 = ready |
| rdy_en_n | input | NUM_SRC | Per-source enable, 0 = source counts |
| ready_o | output | 1 | Synchronized ready to the processor, 1 = ready |

## Verification
The checker verifies the following on every cycle:
- the output holds between falling strobes;
- after each falling strobe, the output equals the first-stage value in two-stage mode, or the qualified inputs in one-stage mode;
- the first stage loads only at rising strobes;
- the two strobes never coincide.

The bench scenarios cover the behaviours that no single-cycle property can show:
- a qualified pulse that falls between the strobes is filtered in two-stage mode but passed in one-stage mode;
- disabled sources never reach the output;
- after reset, the first two-stage falling strobe delivers not-ready.

// File: rtl/ready_sync_pkg.sv
package ready_sync_pkg;

   typedef enum logic {
      MODE_TWO_STAGE = 1'b0,
      MODE_ONE_STAGE = 1'b1
   } sync_mode_e;

   localparam logic READY_NOT = 1'b0;
   localparam logic READY_YES = 1'b1;

endpackage

// File: rtl/rdy_source_qualify.sv
module rdy_source_qualify #(
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] en_n_i,
   output logic               any_ok_o
);
   logic [NUM_SRC-1:0] gated;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign gated[g] = req_i[g] & ~en_n_i[g];
   end

   assign any_ok_o = |gated;

   if (NUM_SRC < 1) begin : g_bad
      $error("rdy_source_qualify: NUM_SRC must be at least 1");
   end
endmodule

// File: rtl/rdy_edge_stage.sv
module rdy_edge_stage #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic d_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RST_VAL;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/rdy_stage_mux.sv
module rdy_stage_mux
   import ready_sync_pkg::*;
(
   input  logic mode_i,
   input  logic first_q_i,
   input  logic direct_i,
   output logic sel_o
);
   sync_mode_e mode;
   assign mode = sync_mode_e'(mode_i);

   always_comb begin
      unique case (mode)
         MODE_TWO_STAGE: sel_o = first_q_i;
         MODE_ONE_STAGE: sel_o = direct_i;
         default:        sel_o = READY_NOT;
      endcase
   end
endmodule

// File: rtl/wait_ready_sync.sv
module wait_ready_sync
   import ready_sync_pkg::*;
#(
   parameter int NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               proc_rise_en,
   input  logic               proc_fall_en,
   input  logic               stage_sel,
   input  logic [NUM_SRC-1:0] rdy_req,
   input  logic [NUM_SRC-1:0] rdy_en_n,
   output logic               ready_o
);
   logic qual_any;
   logic first_q;
   logic out_d;

   if (NUM_SRC < 1) begin : g_bad
      $error("wait_ready_sync: NUM_SRC must be at least 1");
   end

   rdy_source_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
      .req_i    (rdy_req),
      .en_n_i   (rdy_en_n),
      .any_ok_o (qual_any)
   );

   rdy_edge_stage #(.RST_VAL(READY_NOT)) u_first (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (proc_rise_en),
      .d_i    (qual_any),
      .q_o    (first_q)
   );

   rdy_stage_mux u_mux (
      .mode_i    (stage_sel),
      .first_q_i (first_q),
      .direct_i  (qual_any),
      .sel_o     (out_d)
   );

   rdy_edge_stage #(.RST_VAL(READY_NOT)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (proc_fall_en),
      .d_i    (out_d),
      .q_o    (ready_o)
   );
endmodule

// File: rtl/wait_ready_sync_chk.sv
module wait_ready_sync_chk #(
   parameter int NUM_SRC = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               proc_rise_en,
   input logic               proc_fall_en,
   input logic               stage_sel,
   input logic [NUM_SRC-1:0] rdy_req,
   input logic [NUM_SRC-1:0] rdy_en_n,
   input logic               first_q,
   input logic               ready_o
);
   logic merged;
   assign merged = |(rdy_req & ~rdy_en_n);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(proc_rise_en && proc_fall_en)); // R8

   AST_HOLD_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_fall_en |=> $stable(ready_o)); // R5

   AST_TWO_STAGE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_fall_en && !stage_sel) |=> (ready_o == $past(first_q))); // R3

   AST_ONE_STAGE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_fall_en && stage_sel) |=> (ready_o == $past(merged))); // R4

   AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      proc_rise_en |=> (first_q == $past(merged))); // R6

   AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_rise_en |=> $stable(first_q)); // R6
endmodule

bind wait_ready_sync wait_ready_sync_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .proc_rise_en (proc_rise_en),
   .proc_fall_en (proc_fall_en),
   .stage_sel    (stage_sel),
   .rdy_req      (rdy_req),
   .rdy_en_n     (rdy_en_n),
   .first_q      (first_q),
   .ready_o      (ready_o)
);

// File: tb/wait_ready_sync_bench.sv
module wait_ready_sync_bench;
   localparam int NSRC      = 2;
   localparam int CLK_PER   = 10;
   localparam int WDOG_CYC  = 50000;
   localparam int RAND_STEP = 3000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rise_en = 1'b0;
   logic            fall_en = 1'b0;
   logic            sel = 1'b0;
   logic [NSRC-1:0] req = '0;
   logic [NSRC-1:0] en_n = '1;
   logic            ready;

   int checks = 0;
   int fails  = 0;
   int ph     = 0;
   bit last_fall = 1'b0;
   bit last_sel  = 1'b0;
   logic m_first = 1'b0;
   logic m_ready = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   wait_ready_sync #(.NUM_SRC(NSRC)) u_wait_ready_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .proc_rise_en (rise_en),
      .proc_fall_en (fall_en),
      .stage_sel    (sel),
      .rdy_req      (req),
      .rdy_en_n     (en_n),
      .ready_o      (ready)
   );

   // R1: qualified merge as the requirement defines it
   function automatic logic qualified(logic [NSRC-1:0] r, logic [NSRC-1:0] e);
      return |(r & ~e);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_first <= 1'b0;
         m_ready <= 1'b0;
      end else begin
         if (rise_en) m_first <= qualified(req, en_n);
         if (fall_en) m_ready <= sel ? qualified(req, en_n) : m_first;
      end
   end

   task automatic check(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: ready actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // one master cycle: compare, then drive the next cycle's inputs
   task automatic step(logic [NSRC-1:0] r, logic [NSRC-1:0] e, logic s);
      @(negedge clk);
      if (!last_fall)     check("R5", ready, m_ready);
      else if (last_sel)  check("R4", ready, m_ready);
      else                check("R3", ready, m_ready);
      rise_en   = (ph == 0);
      fall_en   = (ph == 1);
      last_fall = (ph == 1);
      last_sel  = s;
      ph        = (ph + 1) % 3;
      req       = r;
      en_n      = e;
      sel       = s;
   endtask

   task automatic idle_until(int want, logic s);
      while (ph != want) step('0, '1, s);
   endtask

   initial begin
      void'($urandom(32'h0BAD_5EED));
      repeat (4) step('0, '1, 1'b0);
      check("R7", ready, 1'b0);
      rst_n = 1'b1;

      // R6/R3: pulse only during the fall cycle, two-stage filters it
      idle_until(1, 1'b0);
      step(2'b01, 2'b10, 1'b0);
      step('0, '1, 1'b0);
      check("R6", ready, 1'b0);
      repeat (4) step('0, '1, 1'b0);
      check("R6", ready, 1'b0);

      // R4: same pulse in one-stage mode passes
      idle_until(1, 1'b1);
      step(2'b10, 2'b01, 1'b1);
      step('0, '1, 1'b1);
      check("R4", ready, 1'b1);
      repeat (3) step('0, '1, 1'b1);
      check("R4", ready, 1'b0);

      // R3: held ready in two-stage mode arrives at the fall after a rise
      idle_until(0, 1'b0);
      step(2'b11, 2'b00, 1'b0);
      step(2'b11, 2'b00, 1'b0);
      step(2'b11, 2'b00, 1'b0);
      check("R3", ready, 1'b1);

      // R2: requests with their enables high never reach ready
      repeat (12) step(2'b11, 2'b11, 1'b1);
      check("R2", ready, 1'b0);
      repeat (12) step(2'b11, 2'b11, 1'b0);
      check("R2", ready, 1'b0);
      // R1: only one of the two sources enabled and requesting
      repeat (6) step(2'b10, 2'b01, 1'b1);
      check("R1", ready, 1'b1);
      repeat (6) step(2'b01, 2'b01, 1'b1);
      check("R1", ready, 1'b0);

      // R7: reset with ready high, release right before a fall in two-stage mode
      repeat (6) step(2'b11, 2'b00, 1'b0);
      check("R7", ready, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R7", ready, 1'b0);
      idle_until(1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      rise_en = 1'b0; fall_en = 1'b1; last_fall = 1'b1; last_sel = 1'b0;
      ph = 2; req = 2'b11; en_n = 2'b00; sel = 1'b0;
      step(2'b11, 2'b00, 1'b0);
      check("R7", ready, 1'b0);

      // constrained random mix, model-checked each cycle
      for (int i = 0; i < RAND_STEP; i++) begin
         logic s;
         s = ($urandom_range(15) == 0) ? ~sel : sel;
         step(NSRC'($urandom), NSRC'($urandom), s);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule